// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Generator

This block drives a bank of pulse-width-modulated outputs from one shared time base. A programmable divider turns the input clock into local ticks. An 8-bit counter advances once per local tick and wraps after 256 of them, so every channel has the same period, and software can change that period only through the divider setting. Each channel compares the shared counter against its own 8-bit threshold. That threshold sets how long the output stays high at the start of every period.

Software programs the block through a simple single-cycle write port. One control word holds the divider value, split across two 4-bit fields, and a single enable that starts or stops every channel at once. Divider and threshold writes go into holding registers. They are copied into the working registers only at a period boundary, or while the bank is stopped, so a running period is never cut short or stretched.

Top module: `pwm_bank`

## Requirements
- R1: A write to byte offset 0x50 sets the divider value P, with P[3:0] taken from data bits 3:0 and P[7:4] taken from data bits 14:11, and sets the shared enable from data bit 9. A write to byte offset 4*i (i < NCH) sets the threshold N of channel i from data bits 7:0.
- R2: While enabled, every period lasts exactly 256*(P+1) input clock cycles, and a new period starts with all outputs high.
- R3: With threshold N, a channel is high for the first (N+1)*(P+1) clock cycles of each period and low for the rest of it.
- R4: A threshold of 255 keeps the channel high through the whole period, with no low cycle between periods.
- R5: After a write that clears the enable, every output is low from the next clock cycle on. After a write that sets the enable, outputs go high on the second clock edge after the write and a fresh period begins there.
- R6: A divider or threshold write made while the bank is running leaves the current period unchanged. The new value takes effect from the next period.
- R7: While reset is asserted and right after it, all outputs are low and the bank is stopped.
- R8: A write to any offset other than those in R1 changes neither the current period nor any later period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | AW (8) | Byte offset of the write |
| wr_data | input | DW (32) | Write data |
| pwm_o | output | NCH (4) | One PWM output per channel |

## Verification
The hardest situation to reach from the ports is a write that lands in the middle of a running period, because its effect must stay invisible until the counter wraps. The stimulus handles this by issuing the write from inside the loop that measures a period, at a chosen cycle index. It then measures the current period and the following one back to back and compares both against the old and new settings. The same mechanism places writes to unmapped offsets mid-period. A divider value with both nibbles nonzero checks the split field together with a long period.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 4,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] CTRL_OFS = 8'h50
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o
);
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [7:0] ps_reg, ps_act, pc;
  logic [CNT_W-1:0] cnt;
  logic en_q, run;
  logic [NCH-1:0][CNT_W-1:0] cmp_reg, cmp_act;

  wire sel_ctrl = wr_en && (wr_addr == CTRL_OFS);
  wire tick = run && (pc == ps_act);
  wire wrap = tick && (cnt == CNT_TOP);
  wire load = !run || wrap;
  wire unused_bits = ^{wr_data[DW-1:15], wr_data[10], wr_data[8:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_reg <= '0;
      en_q   <= 1'b0;
      run    <= 1'b0;
    end else begin
      if (sel_ctrl) begin
        ps_reg <= {wr_data[14:11], wr_data[3:0]};
        en_q   <= wr_data[9];
      end
      run <= en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pc  <= '0;
      cnt <= '0;
    end else if (tick) begin
      pc  <= '0;
      cnt <= cnt + 1'b1;
    end else begin
      pc  <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ps_act <= '0;
    else if (load) ps_act <= ps_reg;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] CH_OFS = AW'(4 * i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_reg[i] <= '0;
        cmp_act[i] <= '0;
      end else begin
        if (wr_en && wr_addr == CH_OFS) cmp_reg[i] <= wr_data[CNT_W-1:0];
        if (load) cmp_act[i] <= cmp_reg[i];
      end
    end
    assign pwm_o[i] = en_q & run & (cnt <= cmp_act[i]);
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en_q,
  input logic                 run,
  input logic                 tick,
  input logic                 wrap,
  input logic [7:0]           pc,
  input logic [7:0]           cnt,
  input logic [7:0]           ps_act,
  input logic [NCH-1:0][7:0]  cmp_act,
  input logic [NCH-1:0]       pwm_o
);
  p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> pwm_o == '0);

  p_pc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pc <= ps_act);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == 8'($past(cnt) + 8'd1));

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  p_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(ps_act) && $stable(cmp_act)));

  for (genvar i = 0; i < NCH; i++) begin : g_full
    p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && run && cmp_act[i] == 8'hFF) |-> pwm_o[i]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .run(run), .tick(tick),
  .wrap(wrap), .pc(pc), .cnt(cnt), .ps_act(ps_act),
  .cmp_act(cmp_act), .pwm_o(pwm_o)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NCH = 4;
  localparam logic [7:0] CTRL = 8'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NCH-1:0] pwm_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_bank #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  function automatic logic [31:0] ctrl_word(input int p, input bit en);
    return (32'(p >> 4) << 11) | (32'(en) << 9) | 32'(p & 15);
  endfunction

  function automatic int high_len(input int p, input int n);
    return (n + 1) * (p + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic start(input int p, input int n[NCH]);
    wr(CTRL, 32'h0);
    for (int c = 0; c < NCH; c++) wr(8'(4 * c), 32'(n[c]));
    wr(CTRL, ctrl_word(p, 1'b1));
    @(negedge clk);
    check(pwm_o == '0, "R5 first cycle after enable write", int'(pwm_o), 0);
  endtask

  task automatic measure(input int p, input int n[NCH], input int mid,
                         input logic [7:0] ma, input logic [31:0] md, input string tag);
    int len = 256 * (p + 1);
    int hc[NCH];
    for (int c = 0; c < NCH; c++) hc[c] = 0;
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (pwm_o[c]) hc[c]++;
        if (j == 0)
          check(pwm_o[c] == 1'b1, {"R2 period start high ", tag}, int'(pwm_o[c]), 1);
        if (j == len - 1)
          check(pwm_o[c] == (n[c] == 255), {"R2/R4 last cycle of period ", tag},
                int'(pwm_o[c]), int'(n[c] == 255));
      end
      if (j == mid) begin
        wr_en = 1'b1; wr_addr = ma; wr_data = md;
      end
      if (j == mid + 1) wr_en = 1'b0;
    end
    for (int c = 0; c < NCH; c++)
      check(hc[c] == high_len(p, n[c]), {"R3 high time ", tag}, hc[c], high_len(p, n[c]));
  endtask

  initial begin
    int n[NCH];
    int p;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(pwm_o == '0, "R7 outputs low in reset", int'(pwm_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_o == '0, "R7 outputs low after reset", int'(pwm_o), 0);

    // R1 split divider field, R8 unmapped writes mid-period
    n = '{0, 127, 255, 16};
    start(42, n);
    measure(42, n, 300, 8'h4C, 32'hFFFF_FFFF, "R1 R8 p=42");
    measure(42, n, 5000, 8'h54, 32'hFFFF_FFFF, "R1 R8 p=42 second");
    measure(42, n, -5, 8'h00, 32'h0, "R8 p=42 third");

    // R6 threshold write mid-period
    n = '{10, 20, 30, 40};
    start(1, n);
    measure(1, n, 100, 8'h00, 32'd200, "R6 before thr change");
    n[0] = 200;
    measure(1, n, -5, 8'h00, 32'h0, "R6 after thr change");

    // R6 divider write mid-period, other control bits set and ignored
    measure(1, n, 60, CTRL, ctrl_word(3, 1'b1) | 32'h0000_85F0, "R6 before div change");
    measure(3, n, -5, 8'h00, 32'h0, "R6 after div change");

    // R5 disable holds every output low
    wr(CTRL, ctrl_word(3, 1'b0));
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k % 10 == 0) check(pwm_o == '0, "R5 disabled outputs low", int'(pwm_o), 0);
    end

    // random configurations
    for (int k = 0; k < 6; k++) begin
      p = int'($urandom % 4);
      for (int c = 0; c < NCH; c++) n[c] = int'($urandom % 256);
      n[k % NCH] = 255;
      n[(k + 1) % NCH] = 0;
      start(p, n);
      measure(p, n, -5, 8'h00, 32'h0, "R3 R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule